// File: doc/BRIEF.md
# Secure Monitor Vector Base Register

This block holds the base address of the exception vector table used when the core enters secure monitor mode. It sits in the system-control coprocessor space. It decodes each coprocessor register access from the pipeline and checks it against the current security world and privilege level. It also checks a pin that blocks secure writes. A permitted access completes, and a refused one raises an undefined-instruction flag in the same cycle.

The block also works out the branch target for exceptions that enter monitor mode. The secure monitor call always uses this base. IRQ, FIQ and external aborts use it only when their route enables are set. Every other exception is left to the normal vector logic, which is told by a low vector-valid output.

Requests carry a single valid strobe and are never stalled: the block accepts one access in every cycle that `req_valid` is high, so it applies no back-pressure. Read data, the undefined flag and the vector outputs are combinational in the request cycle. A write lands on the next rising clock edge.

Top module: `monvec_base_unit`

## Requirements
- R1: After reset the stored base is 0x00000000.
- R2: Bits [4:0] of the register always read as zero. Write data in those bits is discarded, and bits [31:5] are stored.
- R3: The register is selected only when opcode_1=0, CRn=12, CRm=0 and opcode_2=1. Any other request leaves the base unchanged, does not raise `undef`, and returns 0 on `rd_data`.
- R4: A selected read in secure privileged mode (`sec_state`=1, `priv_mode`=1) returns the base on `rd_data` in the request cycle. A selected write in that mode with `sec_wr_disable`=0 updates the base on the next rising edge.
- R5: A selected read or write from non-secure privileged mode, or from user mode (`priv_mode`=0) in either world, raises `undef`. It returns 0 on `rd_data` and leaves the base unchanged.
- R6: A selected secure privileged write while `sec_wr_disable`=1 raises `undef` and does not update the base. A read in the same state still succeeds.
- R7: `undef` is high only in a cycle with `req_valid`=1 and a selected, refused request. It is a single-cycle pulse for each refused request.
- R8: Exception code 0 (secure monitor call) always gives `vec_valid`=1 and `vec_addr` = base + 0x08.
- R9: Code 1 (prefetch external abort, offset 0x0C) and code 2 (data external abort, offset 0x10) are vectored only when `route_ext_abt`=1. Code 3 (IRQ, offset 0x18) is vectored only when `route_irq`=1. Code 4 (FIQ, offset 0x1C) is vectored only when `route_fiq`=1.
- R10: Codes 5 to 7, any exception whose route enable is clear, and any cycle with `exc_valid`=0 give `vec_valid`=0 and `vec_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Coprocessor access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op1 | input | 3 | opcode_1 field |
| req_crn | input | 4 | CRn field |
| req_crm | input | 4 | CRm field |
| req_op2 | input | 3 | opcode_2 field |
| req_wdata | input | 32 | Write data |
| sec_state | input | 1 | 1 = secure world |
| priv_mode | input | 1 | 1 = privileged mode |
| sec_wr_disable | input | 1 | Blocks secure writes when high |
| exc_valid | input | 1 | An exception is being taken |
| exc_type | input | 3 | Exception code (0 SMC, 1 prefetch abort, 2 data abort, 3 IRQ, 4 FIQ, 5-7 others) |
| route_irq | input | 1 | Send IRQ to monitor mode |
| route_fiq | input | 1 | Send FIQ to monitor mode |
| route_ext_abt | input | 1 | Send external aborts to monitor mode |
| rd_data | output | 32 | Read data for a permitted selected read, else 0 |
| undef | output | 1 | Refused access, undefined-instruction indication |
| vec_valid | output | 1 | Exception is vectored through the monitor base |
| vec_addr | output | 32 | Monitor vector target, 0 when not valid |

## Verification
The assertions assume that the access fields, mode bits and disable pin stay steady for the whole cycle that `req_valid` is high. They also assume that `exc_type` has meaning only while `exc_valid` is high. The bench changes every input only at the falling clock edge and drops `req_valid` after each request edge. It drives the exception inputs separately from accesses, so both assumptions hold throughout the stimulus.

// File: rtl/mvb_pkg.sv
package mvb_pkg;
  localparam int ADDR_W   = 32;
  localparam int LOW_BITS = 5;

  typedef enum logic [2:0] {
    EXC_SMC  = 3'd0,
    EXC_PABT = 3'd1,
    EXC_DABT = 3'd2,
    EXC_IRQ  = 3'd3,
    EXC_FIQ  = 3'd4,
    EXC_UND  = 3'd5,
    EXC_SVC  = 3'd6,
    EXC_RST  = 3'd7
  } exc_e;

  function automatic logic [LOW_BITS-1:0] vec_offset(input exc_e t);
    case (t)
      EXC_SMC:  vec_offset = 5'h08;
      EXC_PABT: vec_offset = 5'h0C;
      EXC_DABT: vec_offset = 5'h10;
      EXC_IRQ:  vec_offset = 5'h18;
      EXC_FIQ:  vec_offset = 5'h1C;
      default:  vec_offset = 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/mvb_access_ctrl.sv
module mvb_access_ctrl #(
  parameter logic [2:0] SEL_OP1 = 3'd0,
  parameter logic [3:0] SEL_CRN = 4'd12,
  parameter logic [3:0] SEL_CRM = 4'd0,
  parameter logic [2:0] SEL_OP2 = 3'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [2:0] req_op1,
  input  logic [3:0] req_crn,
  input  logic [3:0] req_crm,
  input  logic [2:0] req_op2,
  input  logic       sec_state,
  input  logic       priv_mode,
  input  logic       sec_wr_disable,
  output logic       rd_en,
  output logic       wr_en,
  output logic       undef
);
  logic hit, sec_priv, allowed;

  assign hit      = req_valid && (req_op1 == SEL_OP1) && (req_crn == SEL_CRN)
                    && (req_crm == SEL_CRM) && (req_op2 == SEL_OP2);
  assign sec_priv = sec_state && priv_mode;
  assign allowed  = sec_priv && !(req_write && sec_wr_disable);

  assign rd_en = hit && allowed && !req_write;
  assign wr_en = hit && allowed && req_write;
  assign undef = hit && !allowed;

  // R5: non-secure or user accesses never complete
  p_mode_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_state || !priv_mode) |-> !(rd_en || wr_en));

  // R6: disable pin blocks every write
  p_disable_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr_disable |-> !wr_en);

  // R7: undefined flag only with a request present
  p_undef_with_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> req_valid && !(rd_en || wr_en));
endmodule

// File: rtl/mvb_base_reg.sv
module mvb_base_reg #(
  parameter int ADDR_W   = mvb_pkg::ADDR_W,
  parameter int LOW_BITS = mvb_pkg::LOW_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base
);
  localparam int HI_W = ADDR_W - LOW_BITS;

  logic [HI_W-1:0]     base_hi;
  logic [LOW_BITS-1:0] unused_low;

  assign unused_low = wdata[LOW_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     base_hi <= '0;
    else if (wr_en) base_hi <= wdata[ADDR_W-1:LOW_BITS];
  end

  assign base = {base_hi, {LOW_BITS{1'b0}}};

  // R4: an accepted write is visible after the next edge
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> base[ADDR_W-1:LOW_BITS] == $past(wdata[ADDR_W-1:LOW_BITS]));

  // R5: without a write the base holds
  p_base_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base));
endmodule

// File: rtl/mvb_vector_gen.sv
module mvb_vector_gen
  import mvb_pkg::*;
#(
  parameter int ADDR_W   = mvb_pkg::ADDR_W,
  parameter int LOW_BITS = mvb_pkg::LOW_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic              exc_valid,
  input  logic [2:0]        exc_type,
  input  logic              route_irq,
  input  logic              route_fiq,
  input  logic              route_ext_abt,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int NUM_TYPES = 8;

  logic [NUM_TYPES-1:0] routed;

  generate
    for (genvar k = 0; k < NUM_TYPES; k++) begin : g_route
      if (k == int'(EXC_SMC))                            assign routed[k] = 1'b1;
      else if (k == int'(EXC_PABT) || k == int'(EXC_DABT)) assign routed[k] = route_ext_abt;
      else if (k == int'(EXC_IRQ))                       assign routed[k] = route_irq;
      else if (k == int'(EXC_FIQ))                       assign routed[k] = route_fiq;
      else                                               assign routed[k] = 1'b0;
    end
  endgenerate

  assign vec_valid = exc_valid && routed[exc_type];
  assign vec_addr  = vec_valid
                   ? {base[ADDR_W-1:LOW_BITS], vec_offset(exc_e'(exc_type))}
                   : '0;

  // R8: the monitor call is always vectored
  p_smc_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_type == 3'd0) |-> vec_valid);

  // R10: nothing is vectored without an exception
  p_no_exc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> !vec_valid && vec_addr == '0);
endmodule

// File: rtl/monvec_base_unit.sv
module monvec_base_unit
  import mvb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic [31:0] req_wdata,
  input  logic        sec_state,
  input  logic        priv_mode,
  input  logic        sec_wr_disable,
  input  logic        exc_valid,
  input  logic [2:0]  exc_type,
  input  logic        route_irq,
  input  logic        route_fiq,
  input  logic        route_ext_abt,
  output logic [31:0] rd_data,
  output logic        undef,
  output logic        vec_valid,
  output logic [31:0] vec_addr
);
  logic              rd_en, wr_en;
  logic [ADDR_W-1:0] base;

  mvb_access_ctrl u_acc (
    .clk, .rst_n, .req_valid, .req_write, .req_op1, .req_crn, .req_crm,
    .req_op2, .sec_state, .priv_mode, .sec_wr_disable,
    .rd_en, .wr_en, .undef
  );

  mvb_base_reg #(.ADDR_W(ADDR_W), .LOW_BITS(LOW_BITS)) u_reg (
    .clk, .rst_n, .wr_en, .wdata(req_wdata), .base
  );

  mvb_vector_gen #(.ADDR_W(ADDR_W), .LOW_BITS(LOW_BITS)) u_vec (
    .clk, .rst_n, .base, .exc_valid, .exc_type, .route_irq, .route_fiq,
    .route_ext_abt, .vec_valid, .vec_addr
  );

  assign rd_data = rd_en ? base : '0;

  // R2: low bits of read data are always zero
  p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[LOW_BITS-1:0] == '0);

  // R3: unselected or refused reads return zero
  p_rd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
endmodule

// File: tb/monvec_base_unit_tb.sv
module monvec_base_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [2:0]  req_op1 = 0, req_op2 = 0;
  logic [3:0]  req_crn = 0, req_crm = 0;
  logic [31:0] req_wdata = 0;
  logic        sec_state = 0, priv_mode = 0, sec_wr_disable = 0;
  logic        exc_valid = 0, route_irq = 0, route_fiq = 0, route_ext_abt = 0;
  logic [2:0]  exc_type = 0;
  logic [31:0] rd_data, vec_addr;
  logic        undef, vec_valid;

  int total = 0, bad = 0;
  logic [31:0] model;

  always #5 clk = ~clk;

  monvec_base_unit u_dut (.*);

  // row: {write, secure, privileged, disable, expected undef}
  localparam logic [4:0] ACC_TBL [16] = '{
    5'b00001, 5'b00011, 5'b00101, 5'b00111,
    5'b01001, 5'b01011, 5'b01100, 5'b01110,
    5'b10001, 5'b10011, 5'b10101, 5'b10111,
    5'b11001, 5'b11011, 5'b11100, 5'b11111
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [2:0] o1, input logic [3:0] n,
                     input logic [3:0] m, input logic [2:0] o2, input logic [31:0] d,
                     input logic s, input logic p, input logic dis,
                     output logic u, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_op1 = o1; req_crn = n; req_crm = m; req_op2 = o2;
    req_wdata = d; sec_state = s; priv_mode = p; sec_wr_disable = dis;
    #1; u = undef; r = rd_data;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; sec_wr_disable = 0;
  endtask

  task automatic sel(input logic wr, input logic [31:0] d, input logic s, input logic p,
                     input logic dis, output logic u, output logic [31:0] r);
    acc(wr, 3'd0, 4'd12, 4'd0, 3'd1, d, s, p, dis, u, r);
  endtask

  task automatic peek(output logic [31:0] r);
    logic u;
    sel(1'b0, 32'h0, 1'b1, 1'b1, 1'b0, u, r);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic u;
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset value
    peek(r);
    chk(r == 0, "R1 reset base", r, 0);
    @(negedge clk); exc_valid = 1; exc_type = 3'd0; #1;
    chk(vec_addr == 32'h8, "R1 reset vector", vec_addr, 32'h8);
    exc_valid = 0;

    // R2 low bits discarded
    sel(1'b1, 32'hABCDE7FF, 1'b1, 1'b1, 1'b0, u, r);
    model = 32'hABCDE7E0;
    peek(r);
    chk(r == model, "R2 low bits", r, model);

    // R4 R5 R6 access table
    for (int i = 0; i < 16; i++) begin
      logic [4:0] row;
      logic [31:0] nd, exp_rd;
      row = ACC_TBL[i];
      nd = 32'h1000_0000 + (i << 8) + 32'h1F;
      sel(row[4], nd, row[3], row[2], row[1], u, r);
      chk(u == row[0], $sformatf("R5 R6 undef row %0d", i), {31'd0, u}, {31'd0, row[0]});
      exp_rd = (!row[4] && !row[0]) ? model : 32'h0;
      chk(r == exp_rd, $sformatf("R4 R5 rd row %0d", i), r, exp_rd);
      if (row[4] && !row[0]) model = nd & 32'hFFFF_FFE0;
      peek(r);
      chk(r == model, $sformatf("R4 R6 base row %0d", i), r, model);
    end

    // R3 wrong selector fields
    for (int f = 0; f < 4; f++) begin
      logic [2:0] o1, o2;
      logic [3:0] n, m;
      o1 = (f == 0) ? 3'd1 : 3'd0;
      n  = (f == 1) ? 4'd11 : 4'd12;
      m  = (f == 2) ? 4'd1 : 4'd0;
      o2 = (f == 3) ? 3'd0 : 3'd1;
      acc(1'b1, o1, n, m, o2, 32'h5555_5540, 1'b0, 1'b0, 1'b0, u, r);
      chk(u == 0, "R3 no undef on miss", {31'd0, u}, 0);
      acc(1'b1, o1, n, m, o2, 32'h5555_5540, 1'b1, 1'b1, 1'b0, u, r);
      acc(1'b0, o1, n, m, o2, 32'h0, 1'b1, 1'b1, 1'b0, u, r);
      chk(r == 0, "R3 rd zero on miss", r, 0);
      peek(r);
      chk(r == model, "R3 base unchanged", r, model);
    end

    // R7 pulse width
    sel(1'b0, 0, 1'b0, 1'b1, 1'b0, u, r);
    #1;
    chk(undef == 0, "R7 undef single cycle", {31'd0, undef}, 0);

    // R8 R9 R10 vector table
    sel(1'b1, 32'h8765_4320, 1'b1, 1'b1, 1'b0, u, r);
    model = 32'h8765_4320;
    for (int t = 0; t < 8; t++) begin
      for (int e = 0; e < 8; e++) begin
        logic ev;
        logic [31:0] ea;
        logic [4:0] off;
        @(negedge clk);
        exc_valid = 1; exc_type = 3'(t);
        route_irq = e[0]; route_fiq = e[1]; route_ext_abt = e[2];
        case (t)
          0: begin ev = 1;    off = 5'h08; end
          1: begin ev = e[2]; off = 5'h0C; end
          2: begin ev = e[2]; off = 5'h10; end
          3: begin ev = e[0]; off = 5'h18; end
          4: begin ev = e[1]; off = 5'h1C; end
          default: begin ev = 0; off = 0; end
        endcase
        ea = ev ? (model | {27'd0, off}) : 32'h0;
        #1;
        chk(vec_valid == ev, $sformatf("R8 R9 R10 valid t%0d e%0d", t, e), {31'd0, vec_valid}, {31'd0, ev});
        chk(vec_addr == ea, $sformatf("R8 R9 R10 addr t%0d e%0d", t, e), vec_addr, ea);
      end
    end
    @(negedge clk);
    exc_valid = 0; exc_type = 0; route_irq = 1; route_fiq = 1; route_ext_abt = 1; #1;
    chk(!vec_valid && vec_addr == 0, "R10 no exception", vec_addr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule